// File: doc/BRIEF.md
# DSP Host Port Request and Interrupt Logic

This block sits on the host side of a link that moves 24-bit words between a DSP and a host CPU through byte-wide registers. The host sees a control byte, a status byte and three data bytes (high, middle, low). Reading the data bytes returns the word the DSP last pushed. Writing them builds the word handed to the DSP. On the DSP side, a push strobe delivers a word and a pop strobe takes one.

The block keeps two flags: receive-full and transmit-empty. Each flag is gated by its own enable in the control byte. The gated flags are combined into a single host request line. That line is never latched, so it follows the flags at all times. It is mirrored in status bit 7. It is also offered to the CPU as a level-sensitive interrupt at priority 6 with vector 0x0F.

The interrupt is qualified by the CPU's current mask. As a result, a request that vanishes while the CPU is masked leaves nothing pending once the mask is lowered. Selecting DMA mode in the control byte holds the request line low.

Top module: `hostreq_top`

## Requirements
- R1: After reset, receive-full is 0, transmit-empty is 1, and the control byte reads 0x00. The status byte (address 1) therefore reads 0x02, and `host_req` and `irq_pend` are both 0.
- R2: Outside DMA mode, `host_req` is 1 exactly when (receive-full AND control bit 0) OR (transmit-empty AND control bit 1). It drops only when both gated terms are clear. The status byte layout is: bit 0 receive-full, bit 1 transmit-empty, bit 7 request state.
- R3: A DSP push while receive-full is 0 stores the word and sets receive-full. Host reads of address 5 (high), 6 (middle) and 7 (low) return bits 23:16, 15:8 and 7:0 of that word.
- R4: A DSP push while receive-full is 1 is ignored, and the stored word is kept. `d_overrun` is high during that push cycle.
- R5: A host read of address 7 clears receive-full at the clock edge that ends the read. Reads of addresses 5 and 6 leave it set. `host_req` falls on that same edge if no other gated term holds.
- R6: Host writes to addresses 5 and 6 hold the upper bytes. A write to address 7 delivers {high, middle, low} on `d_pop_word`, clears transmit-empty and raises `d_tx_ready`. A DSP pop while the word is waiting sets transmit-empty again.
- R7: Control bit 2 selects DMA mode. While it is set, `host_req` and `irq_pend` stay 0 whatever the flags are.
- R8: `irq_pend` is 1 exactly when `host_req` is 1 and `cpu_mask` is below 6. `irq_level` reads 6 and `irq_vector` reads 0x0F. If the request drops while the mask is 7, lowering the mask to 5 afterwards leaves `irq_pend` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 3 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte (0 when not reading) |
| d_push | input | 1 | DSP pushes a word toward the host |
| d_push_word | input | 24 | Word pushed by the DSP |
| d_overrun | output | 1 | Push refused because receive-full was set |
| d_pop | input | 1 | DSP takes the host-written word |
| d_pop_word | output | 24 | Word written by the host |
| d_tx_ready | output | 1 | A host-written word waits for the DSP |
| cpu_mask | input | 3 | Current CPU interrupt mask |
| host_req | output | 1 | Host request line |
| irq_pend | output | 1 | Interrupt offered to the CPU |
| irq_level | output | 3 | Interrupt priority (6) |
| irq_vector | output | 8 | Interrupt vector number (0x0F) |

## Verification
The bench builds the block with its default parameters: 24-bit words of three 8-bit bytes, priority 6 and vector 0x0F. Those values place the three data bytes at addresses 5 to 7. They also give the mask threshold its meaning, so that mask 5 admits the interrupt and mask 7 blocks it. The masked-drop scenario can then be replayed exactly as the CPU would see it. With both enables on, the bench confirms that clearing one flag keeps the request high.

// File: rtl/hostreq_pkg.sv
package hostreq_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_HI   = 3'd5,
    REG_MID  = 3'd6,
    REG_LO   = 3'd7
  } hreg_e;

  // control byte bit positions
  localparam int CTRL_RXEN = 0;
  localparam int CTRL_TXEN = 1;
  localparam int CTRL_DMA  = 2;

  // status byte bit positions
  localparam int STAT_RXF = 0;
  localparam int STAT_TXE = 1;
  localparam int STAT_REQ = 7;

  // request line: gated flags, forced low in DMA mode
  function automatic logic req_calc(input logic rxf, input logic txe,
                                    input logic rxen, input logic txen,
                                    input logic dma);
    return !dma && ((rxf && rxen) || (txe && txen));
  endfunction

  // CPU admits an interrupt only if its mask is below the level
  function automatic logic irq_admit(input int unsigned mask,
                                     input int unsigned level);
    return mask < level;
  endfunction

  // address of data byte slice i (0 = low byte)
  function automatic logic [ADDR_W-1:0] byte_addr(input int unsigned i);
    return ADDR_W'(int'(REG_LO) - int'(i));
  endfunction

endpackage

// File: rtl/hostreq_rx.sv
module hostreq_rx #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              low_rd,
  output logic              push_take,
  output logic              overrun,
  output logic              rx_full,
  output logic [WORD_W-1:0] rx_word
);

  assign push_take = push && !rx_full;
  assign overrun   = push && rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_word <= '0;
    end else begin
      if (low_rd) rx_full <= 1'b0;
      if (push_take) begin
        rx_full <= 1'b1;
        rx_word <= push_word;
      end
    end
  end

endmodule

// File: rtl/hostreq_tx.sv
module hostreq_tx #(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WORD_W/BYTE_W-1:0]   byte_wr,
  input  logic [BYTE_W-1:0]          wdata,
  input  logic                       pop,
  output logic                       pop_take,
  output logic                       tx_empty,
  output logic [WORD_W-1:0]          tx_word
);

  localparam int NB = WORD_W / BYTE_W;

  logic [BYTE_W-1:0] hold [NB];
  logic [WORD_W-1:0] next_word;

  assign hold[0] = wdata;

  genvar gi;
  generate
    for (gi = 1; gi < NB; gi++) begin : g_hold
      logic [BYTE_W-1:0] hreg;
      always_ff @(posedge clk) begin
        if (!rst_n) hreg <= '0;
        else if (byte_wr[gi]) hreg <= wdata;
      end
      assign hold[gi] = hreg;
    end
  endgenerate

  always_comb begin
    next_word = '0;
    for (int i = 0; i < NB; i++) next_word[i*BYTE_W +: BYTE_W] = hold[i];
  end

  assign pop_take = pop && !tx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_empty <= 1'b1;
      tx_word  <= '0;
    end else begin
      if (pop_take) tx_empty <= 1'b1;
      if (byte_wr[0]) begin
        tx_empty <= 1'b0;
        tx_word  <= next_word;
      end
    end
  end

endmodule

// File: rtl/hostreq_ctrl.sv
module hostreq_ctrl
  import hostreq_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MASK_W    = 3,
  parameter int IRQ_LEVEL = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic [MASK_W-1:0] cpu_mask,
  output logic              rx_en,
  output logic              tx_en,
  output logic              dma_sel,
  output logic              host_req,
  output logic              irq_pend
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
      dma_sel <= 1'b0;
    end else if (ctrl_wr) begin
      rx_en   <= wdata[CTRL_RXEN];
      tx_en   <= wdata[CTRL_TXEN];
      dma_sel <= wdata[CTRL_DMA];
    end
  end

  assign host_req = req_calc(rx_full, tx_empty, rx_en, tx_en, dma_sel);
  assign irq_pend = host_req && irq_admit(int'(cpu_mask), IRQ_LEVEL);

endmodule

// File: rtl/hostreq_top.sv
module hostreq_top
  import hostreq_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int BYTE_W    = 8,
  parameter int MASK_W    = 3,
  parameter int IRQ_LEVEL = 6,
  parameter int IRQ_VEC   = 15,
  parameter int VEC_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [BYTE_W-1:0] h_wdata,
  output logic [BYTE_W-1:0] h_rdata,
  input  logic              d_push,
  input  logic [WORD_W-1:0] d_push_word,
  output logic              d_overrun,
  input  logic              d_pop,
  output logic [WORD_W-1:0] d_pop_word,
  output logic              d_tx_ready,
  input  logic [MASK_W-1:0] cpu_mask,
  output logic              host_req,
  output logic              irq_pend,
  output logic [MASK_W-1:0] irq_level,
  output logic [VEC_W-1:0]  irq_vector
);

  localparam int NB = WORD_W / BYTE_W;

  // named internal events
  logic [NB-1:0]     byte_hit;
  logic [NB-1:0]     tx_byte_wr;
  logic              ctrl_wr;
  logic              rx_low_rd;
  logic              push_take;
  logic              pop_take;
  logic              rx_full;
  logic              tx_empty;
  logic [WORD_W-1:0] rx_word;
  logic              rx_en;
  logic              tx_en;
  logic              dma_sel;

  genvar gb;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_dec
      assign byte_hit[gb]   = (h_addr == byte_addr(gb));
      assign tx_byte_wr[gb] = h_wr && byte_hit[gb];
    end
  endgenerate

  assign ctrl_wr   = h_wr && (h_addr == REG_CTRL);
  assign rx_low_rd = h_rd && byte_hit[0];

  hostreq_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .push(d_push), .push_word(d_push_word), .low_rd(rx_low_rd),
    .push_take(push_take), .overrun(d_overrun),
    .rx_full(rx_full), .rx_word(rx_word)
  );

  hostreq_tx #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .byte_wr(tx_byte_wr), .wdata(h_wdata), .pop(d_pop),
    .pop_take(pop_take), .tx_empty(tx_empty), .tx_word(d_pop_word)
  );

  hostreq_ctrl #(.BYTE_W(BYTE_W), .MASK_W(MASK_W), .IRQ_LEVEL(IRQ_LEVEL)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .wdata(h_wdata),
    .rx_full(rx_full), .tx_empty(tx_empty), .cpu_mask(cpu_mask),
    .rx_en(rx_en), .tx_en(tx_en), .dma_sel(dma_sel),
    .host_req(host_req), .irq_pend(irq_pend)
  );

  assign d_tx_ready = !tx_empty;
  assign irq_level  = MASK_W'(IRQ_LEVEL);
  assign irq_vector = VEC_W'(IRQ_VEC);

  // host read mux
  always_comb begin
    h_rdata = '0;
    if (h_rd) begin
      if (h_addr == REG_CTRL) begin
        h_rdata[CTRL_RXEN] = rx_en;
        h_rdata[CTRL_TXEN] = tx_en;
        h_rdata[CTRL_DMA]  = dma_sel;
      end else if (h_addr == REG_STAT) begin
        h_rdata[STAT_RXF] = rx_full;
        h_rdata[STAT_TXE] = tx_empty;
        h_rdata[STAT_REQ] = host_req;
      end else begin
        for (int i = 0; i < NB; i++)
          if (byte_hit[i]) h_rdata = rx_word[i*BYTE_W +: BYTE_W];
      end
    end
  end

endmodule

// File: rtl/hostreq_chk.sv
module hostreq_chk #(
  parameter int WORD_W    = 24,
  parameter int MASK_W    = 3,
  parameter int IRQ_LEVEL = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_full,
  input logic              tx_empty,
  input logic              rx_en,
  input logic              tx_en,
  input logic              dma_sel,
  input logic              host_req,
  input logic              irq_pend,
  input logic [MASK_W-1:0] cpu_mask,
  input logic              rx_low_rd,
  input logic              push_take,
  input logic              pop_take,
  input logic              tx_low_wr,
  input logic              d_overrun,
  input logic [WORD_W-1:0] rx_word
);

  // R1: reset leaves receive empty and transmit empty-flag set
  a_r1_reset_flags: assert property (@(posedge clk)
    !rst_n |=> (!rx_full && tx_empty));

  // R2 / R7: no request without an enabled flag, none in DMA mode
  a_r2_req_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |-> (!dma_sel && ((rx_full && rx_en) || (tx_empty && tx_en))));

  // R7: DMA mode silences the interrupt
  a_r7_dma_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dma_sel |-> (!host_req && !irq_pend));

  // R3: accepted push sets receive-full
  a_r3_push_sets: assert property (@(posedge clk) disable iff (!rst_n)
    push_take |=> rx_full);

  // R4: refused push keeps the stored word
  a_r4_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    d_overrun |=> (rx_full && $stable(rx_word)));

  // R5: low read clears receive-full
  a_r5_low_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_low_rd && rx_full) |=> !rx_full);

  // R6: DSP pop re-arms transmit-empty
  a_r6_pop_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_take && !tx_low_wr) |=> tx_empty);

  // R6: low write clears transmit-empty
  a_r6_low_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_low_wr |=> !tx_empty);

  // R8: interrupt only with request and an admitting mask
  a_r8_pend_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (host_req && (int'(cpu_mask) < IRQ_LEVEL)));

endmodule

bind hostreq_top hostreq_chk #(
  .WORD_W(WORD_W), .MASK_W(MASK_W), .IRQ_LEVEL(IRQ_LEVEL)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_full(rx_full), .tx_empty(tx_empty),
  .rx_en(rx_en), .tx_en(tx_en), .dma_sel(dma_sel),
  .host_req(host_req), .irq_pend(irq_pend), .cpu_mask(cpu_mask),
  .rx_low_rd(rx_low_rd), .push_take(push_take), .pop_take(pop_take),
  .tx_low_wr(tx_byte_wr[0]), .d_overrun(d_overrun), .rx_word(rx_word)
);

// File: tb/hostreq_top_tb.sv
`timescale 1ns/1ps
module hostreq_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  h_addr = '0;
  logic        h_wr = 1'b0;
  logic        h_rd = 1'b0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic        d_push = 1'b0;
  logic [23:0] d_push_word = '0;
  logic        d_overrun;
  logic        d_pop = 1'b0;
  logic [23:0] d_pop_word;
  logic        d_tx_ready;
  logic [2:0]  cpu_mask = 3'd7;
  logic        host_req;
  logic        irq_pend;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  hostreq_top u_dut (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .d_push(d_push),
    .d_push_word(d_push_word), .d_overrun(d_overrun), .d_pop(d_pop),
    .d_pop_word(d_pop_word), .d_tx_ready(d_tx_ready), .cpu_mask(cpu_mask),
    .host_req(host_req), .irq_pend(irq_pend), .irq_level(irq_level),
    .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1;
    #1 d = h_rdata;
    @(negedge clk); h_rd = 1'b0;
  endtask

  task automatic dpush(input logic [23:0] w, output logic ovr);
    @(negedge clk); d_push = 1'b1; d_push_word = w;
    #1 ovr = d_overrun;
    @(negedge clk); d_push = 1'b0;
  endtask

  task automatic dpop();
    @(negedge clk); d_pop = 1'b1;
    @(negedge clk); d_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] b;
    hread(3'd1, b); chk("R1", "status after reset", b, 8'h02);
    hread(3'd0, b); chk("R1", "control after reset", b, 8'h00);
    chk("R1", "host_req after reset", host_req, 0);
    chk("R1", "irq_pend after reset", irq_pend, 0);
  endtask

  task automatic t_tx_enable_irq();
    logic [7:0] b;
    hwrite(3'd0, 8'h02);
    chk("R2", "req from tx-empty", host_req, 1);
    hread(3'd1, b); chk("R2", "status bit7 mirrors req", b, 8'h82);
    cpu_mask = 3'd7; #1 chk("R8", "mask 7 blocks", irq_pend, 0);
    cpu_mask = 3'd5; #1 chk("R8", "mask 5 admits", irq_pend, 1);
    chk("R8", "level", irq_level, 6);
    chk("R8", "vector", irq_vector, 8'h0F);
  endtask

  task automatic t_tx_word();
    hwrite(3'd5, 8'h12); hwrite(3'd6, 8'h34);
    chk("R6", "upper bytes do not clear tx-empty", d_tx_ready, 0);
    hwrite(3'd7, 8'h56);
    chk("R6", "word to DSP", d_pop_word, 24'h123456);
    chk("R6", "tx ready", d_tx_ready, 1);
    chk("R2", "req drops with tx-empty clear", host_req, 0);
    dpop();
    chk("R6", "pop re-arms tx-empty", d_tx_ready, 0);
    chk("R2", "req back after pop", host_req, 1);
  endtask

  task automatic t_rx_word();
    logic [7:0] b; logic ovr;
    hwrite(3'd0, 8'h01);
    chk("R2", "rx enable only, rx empty", host_req, 0);
    dpush(24'hABCDEF, ovr);
    chk("R4", "no overrun on first push", ovr, 0);
    chk("R3", "req after push", host_req, 1);
    hread(3'd5, b); chk("R3", "high byte", b, 8'hAB);
    hread(3'd6, b); chk("R3", "middle byte", b, 8'hCD);
    chk("R5", "middle read keeps req", host_req, 1);
    hread(3'd7, b); chk("R3", "low byte", b, 8'hEF);
    chk("R5", "low read drops req", host_req, 0);
    hread(3'd1, b); chk("R5", "status after low read", b, 8'h02);
  endtask

  task automatic t_overrun();
    logic [7:0] b; logic ovr;
    dpush(24'h111111, ovr);
    dpush(24'h222222, ovr);
    chk("R4", "overrun flagged", ovr, 1);
    hread(3'd7, b); chk("R4", "first word kept", b, 8'h11);
  endtask

  task automatic t_both();
    logic [7:0] b; logic ovr;
    hwrite(3'd0, 8'h03);
    dpush(24'h0000AA, ovr);
    hread(3'd7, b);
    chk("R2", "req held by tx term after rx clear", host_req, 1);
  endtask

  task automatic t_dma();
    logic ovr;
    hwrite(3'd0, 8'h07);
    dpush(24'h000001, ovr);
    cpu_mask = 3'd0;
    #1 chk("R7", "dma forces req low", host_req, 0);
    chk("R7", "dma keeps irq off", irq_pend, 0);
  endtask

  task automatic t_masked_drop();
    logic [7:0] b;
    cpu_mask = 3'd7;
    hwrite(3'd0, 8'h01);           // rx still full from dma test
    chk("R8", "req while masked", host_req, 1);
    chk("R8", "no irq while masked", irq_pend, 0);
    hread(3'd7, b);
    chk("R5", "req gone after low read", host_req, 0);
    cpu_mask = 3'd5;
    #1 chk("R8", "nothing pending after unmask", irq_pend, 0);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_enable_irq();
    t_tx_word();
    t_rx_word();
    t_overrun();
    t_both();
    t_dma();
    t_masked_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule